// File: doc/BRIEF.md
# Software Interrupt Admission Filter

This block sits between the path that delivers software-generated interrupt requests to a processor and the per-interrupt state storage for that processor's 16 local interrupts. Each request names a target interrupt, the group the sender asks for (secure group 0, secure group 1 or non-secure group 1) and whether the sender runs in the non-secure world. The filter checks the request against the interrupt's resolved group, its 2-bit non-secure access level and the global security-disable input. It then either raises a one-cycle set-pending strobe for that interrupt, together with a strobe that asks the priority logic to re-evaluate, or drops the request silently.

Alongside admission, the block forwards clear-pending masks to the storage. If a request is accepted in the same cycle that a clear targets the same interrupt, the set wins. It also computes, for each of the three groups, whether this processor may be picked as the target of a one-of-N distributed interrupt. All outputs are registered and appear one clock after their inputs.

Group encoding on `req_grp_i` and each 2-bit field of `cfg_grp_i`: 0 = secure group 0, 1 = secure group 1, 2 = non-secure group 1, 3 = reserved. Bit order of `grp_en_i`, `block_i` and `elig_o`: bit 0 = secure group 0, bit 1 = secure group 1, bit 2 = non-secure group 1. Interrupt i uses bits [2i+1:2i] of `cfg_grp_i` and `nsac_i`, and bit i of the masks and strobes.

Top module: `sgf_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `set_pend_o`, `clr_pend_o`, `reeval_o` and `elig_o` are all zero.
- R2: A request whose ID is 16 or above produces no set-pending strobe on any interrupt.
- R3: A secure group 1 request to an interrupt configured as secure group 0 is treated as a secure group 0 request and is accepted, subject to R5.
- R4: A secure group 0 request, after the conversion of R3, to an interrupt not configured as secure group 0 is dropped. Requests for group 1 are not dropped for a group mismatch.
- R5: With `sec_dis_i`=0 and `req_ns_i`=1, a request to a secure group 0 interrupt needs `nsac` >= 1 and a request to a secure group 1 interrupt needs `nsac` >= 2, otherwise it is dropped. A non-secure group 1 interrupt needs no access level.
- R6: With `sec_dis_i`=1 the access-level check of R5 is skipped.
- R7: An accepted request raises bit ID of `set_pend_o` (only that bit) and `reeval_o` for exactly one cycle, one clock after the request. A dropped request raises neither.
- R8: `clr_pend_o` equals `clr_mask_i` delayed by one clock, except that a bit whose interrupt is accepted in the same cycle is cleared from the mask.
- R9: `elig_o[g]` is 1 one clock after the inputs only when `low_power_i`=0 and `grp_en_i[g]`=1.
- R10: `block_i[g]`=1 forces `elig_o[g]` to 0 without affecting the other groups.
- R11: A request with the reserved group code 3 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sec_dis_i | input | 1 | Global security disable |
| req_valid_i | input | 1 | Software interrupt request present this cycle |
| req_id_i | input | 5 | Target interrupt ID |
| req_grp_i | input | 2 | Requested group |
| req_ns_i | input | 1 | Request comes from the non-secure world |
| cfg_grp_i | input | 32 | Resolved group of each interrupt, 2 bits each |
| nsac_i | input | 32 | Non-secure access level of each interrupt, 2 bits each |
| clr_mask_i | input | 16 | Clear-pending request mask |
| low_power_i | input | 1 | Processor is in the low-power state |
| grp_en_i | input | 3 | Global group enables |
| block_i | input | 3 | Per-group block bits for one-of-N selection |
| set_pend_o | output | 16 | Set-pending strobe, one bit per interrupt |
| clr_pend_o | output | 16 | Clear-pending strobe after the set-wins rule |
| reeval_o | output | 1 | Re-evaluate highest-priority pending interrupt |
| elig_o | output | 3 | Per-group one-of-N eligibility |

## Verification
An accepted request and a clear-pending mask can target the same interrupt in the same cycle. The bench provokes this by accepting a request for one interrupt while the clear mask covers that interrupt and a neighbour. It then checks, one clock later, that the set strobe carries the requested bit, that the clear strobe carries only the neighbour, and that a mask with no request behind it passes through unchanged.

// File: rtl/sgf_pkg.sv
package sgf_pkg;

   localparam int unsigned GRP_W  = 2;
   localparam int unsigned NSAC_W = 2;
   localparam int unsigned NUM_GRP = 3;

   typedef enum logic [GRP_W-1:0] {
      GRP_S0   = 2'd0,
      GRP_S1   = 2'd1,
      GRP_NS1  = 2'd2,
      GRP_RSVD = 2'd3
   } grp_e;

   // Admission decision for one interrupt (R3, R4, R5, R6, R11)
   function automatic logic admit_f(input grp_e req, input grp_e cfg,
                                    input logic [NSAC_W-1:0] nsac,
                                    input logic ns, input logic sec_dis);
      grp_e eff;
      eff = req;
      if (req == GRP_RSVD) return 1'b0;
      if (cfg == GRP_S0 && req == GRP_S1) eff = GRP_S0;
      if (eff == GRP_S0 && cfg != GRP_S0) return 1'b0;
      if (ns && !sec_dis) begin
         if (cfg == GRP_S0 && nsac < NSAC_W'(1)) return 1'b0;
         if (cfg == GRP_S1 && nsac < NSAC_W'(2)) return 1'b0;
      end
      return 1'b1;
   endfunction

endpackage

// File: rtl/sgf_lane.sv
module sgf_lane
   import sgf_pkg::*;
(
   input  logic              sel_i,
   input  logic [GRP_W-1:0]  req_grp_i,
   input  logic              req_ns_i,
   input  logic              sec_dis_i,
   input  logic [GRP_W-1:0]  cfg_grp_i,
   input  logic [NSAC_W-1:0] nsac_i,
   output logic              accept_o
);

   grp_e req_g;
   grp_e cfg_g;

   always_comb begin
      req_g    = grp_e'(req_grp_i);
      cfg_g    = grp_e'(cfg_grp_i);
      accept_o = sel_i && admit_f(req_g, cfg_g, nsac_i, req_ns_i, sec_dis_i);
   end

   always_comb begin
      // R4
      grp_mismatch_chk: assert (!(sel_i && req_g == GRP_S0 && cfg_g != GRP_S0) || !accept_o);
      // R5
      nsac_level_chk: assert (!(sel_i && req_ns_i && !sec_dis_i && cfg_g == GRP_S1
                                && nsac_i < NSAC_W'(2)) || !accept_o);
   end

endmodule

// File: rtl/sgf_elig.sv
module sgf_elig
   import sgf_pkg::*;
#(
   parameter int unsigned N_GRP = NUM_GRP
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             low_power_i,
   input  logic [N_GRP-1:0] grp_en_i,
   input  logic [N_GRP-1:0] block_i,
   output logic [N_GRP-1:0] elig_o
);

   logic [N_GRP-1:0] elig_d;

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      assign elig_d[g] = !low_power_i && grp_en_i[g] && !block_i[g];
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) elig_o <= '0;
      else         elig_o <= elig_d;
   end

   // R9
   low_power_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(low_power_i) |-> elig_o == '0);

   // R10
   block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (elig_o & $past(block_i)) == '0);

endmodule

// File: rtl/sgf_filter.sv
module sgf_filter
   import sgf_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 16,
   parameter int unsigned ID_W    = 5
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      sec_dis_i,
   input  logic                      req_valid_i,
   input  logic [ID_W-1:0]           req_id_i,
   input  logic [GRP_W-1:0]          req_grp_i,
   input  logic                      req_ns_i,
   input  logic [NUM_IRQ*GRP_W-1:0]  cfg_grp_i,
   input  logic [NUM_IRQ*NSAC_W-1:0] nsac_i,
   input  logic [NUM_IRQ-1:0]        clr_mask_i,
   input  logic                      low_power_i,
   input  logic [NUM_GRP-1:0]        grp_en_i,
   input  logic [NUM_GRP-1:0]        block_i,
   output logic [NUM_IRQ-1:0]        set_pend_o,
   output logic [NUM_IRQ-1:0]        clr_pend_o,
   output logic                      reeval_o,
   output logic [NUM_GRP-1:0]        elig_o
);

   localparam int unsigned ID_SPAN = 1 << ID_W;

   if (NUM_IRQ < 1 || NUM_IRQ > ID_SPAN) begin : g_bad_cfg
      $error("sgf_filter: NUM_IRQ must lie in 1..2**ID_W");
   end

   logic [NUM_IRQ-1:0] hit;

   for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_lane
      sgf_lane u_lane (
         .sel_i     (req_valid_i && req_id_i == ID_W'(gi)),
         .req_grp_i (req_grp_i),
         .req_ns_i  (req_ns_i),
         .sec_dis_i (sec_dis_i),
         .cfg_grp_i (cfg_grp_i[gi*GRP_W +: GRP_W]),
         .nsac_i    (nsac_i[gi*NSAC_W +: NSAC_W]),
         .accept_o  (hit[gi])
      );
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         set_pend_o <= '0;
         clr_pend_o <= '0;
         reeval_o   <= 1'b0;
      end else begin
         set_pend_o <= hit;
         clr_pend_o <= clr_mask_i & ~hit;
         reeval_o   <= |hit;
      end
   end

   sgf_elig #(.N_GRP(NUM_GRP)) u_elig (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .low_power_i (low_power_i),
      .grp_en_i    (grp_en_i),
      .block_i     (block_i),
      .elig_o      (elig_o)
   );

   // R2
   id_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(req_valid_i && ({1'b0, req_id_i} >= (ID_W+1)'(NUM_IRQ))) |-> set_pend_o == '0);

   // R7
   strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(set_pend_o));

   // R7
   strobe_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|set_pend_o) |-> $past(req_valid_i));

   // R8
   clr_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_pend_o & ~$past(clr_mask_i)) == '0);

endmodule

// File: tb/sgf_filter_tb.sv
`timescale 1ns/1ps
module sgf_filter_tb;

   localparam int NUM_IRQ = 16;
   localparam int ID_W    = 5;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                sec_dis = 1'b0;
   logic                req_valid = 1'b0;
   logic [ID_W-1:0]     req_id = '0;
   logic [1:0]          req_grp = '0;
   logic                req_ns = 1'b0;
   logic [2*NUM_IRQ-1:0] cfg_grp = '0;
   logic [2*NUM_IRQ-1:0] nsac = '0;
   logic [NUM_IRQ-1:0]  clr_mask = '0;
   logic                low_power = 1'b0;
   logic [2:0]          grp_en = '0;
   logic [2:0]          block = '0;
   logic [NUM_IRQ-1:0]  set_pend;
   logic [NUM_IRQ-1:0]  clr_pend;
   logic                reeval;
   logic [2:0]          elig;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sgf_filter #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .sec_dis_i(sec_dis),
      .req_valid_i(req_valid), .req_id_i(req_id), .req_grp_i(req_grp),
      .req_ns_i(req_ns), .cfg_grp_i(cfg_grp), .nsac_i(nsac),
      .clr_mask_i(clr_mask), .low_power_i(low_power), .grp_en_i(grp_en),
      .block_i(block), .set_pend_o(set_pend), .clr_pend_o(clr_pend),
      .reeval_o(reeval), .elig_o(elig)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // {exp, id[4:0], grp[1:0], cfg[1:0], ns, sec_dis, nsac[1:0]}
   // groups: 0 secure g0, 1 secure g1, 2 non-secure g1, 3 reserved
   localparam int NV = 15;
   localparam logic [13:0] VEC [NV] = '{
      {1'b1, 5'd3,  2'd0, 2'd0, 1'b0, 1'b0, 2'd0},  // R4 matching group 0
      {1'b1, 5'd4,  2'd1, 2'd0, 1'b0, 1'b0, 2'd0},  // R3 downgrade
      {1'b0, 5'd5,  2'd0, 2'd1, 1'b0, 1'b0, 2'd0},  // R4 g0 to secure g1
      {1'b0, 5'd6,  2'd0, 2'd2, 1'b0, 1'b0, 2'd0},  // R4 g0 to non-secure g1
      {1'b1, 5'd7,  2'd1, 2'd1, 1'b0, 1'b0, 2'd0},  // R4 g1 match
      {1'b1, 5'd8,  2'd2, 2'd2, 1'b1, 1'b0, 2'd0},  // R5 ns g1 needs no level
      {1'b0, 5'd9,  2'd0, 2'd0, 1'b1, 1'b0, 2'd0},  // R5 g0 level 0
      {1'b1, 5'd10, 2'd0, 2'd0, 1'b1, 1'b0, 2'd1},  // R5 g0 level 1
      {1'b0, 5'd11, 2'd1, 2'd1, 1'b1, 1'b0, 2'd1},  // R5 g1s level 1
      {1'b1, 5'd12, 2'd1, 2'd1, 1'b1, 1'b0, 2'd2},  // R5 g1s level 2
      {1'b1, 5'd13, 2'd1, 2'd1, 1'b1, 1'b1, 2'd0},  // R6 check skipped
      {1'b1, 5'd14, 2'd0, 2'd0, 1'b1, 1'b1, 2'd0},  // R6 check skipped
      {1'b0, 5'd15, 2'd3, 2'd2, 1'b0, 1'b0, 2'd0},  // R11 reserved code
      {1'b1, 5'd0,  2'd2, 2'd1, 1'b0, 1'b0, 2'd0},  // R4 g1 mismatch kept
      {1'b0, 5'd1,  2'd1, 2'd0, 1'b1, 1'b0, 2'd0}   // R5 after downgrade
   };

   initial begin
      repeat (3) @(negedge clk);
      // R1 outputs during reset
      check("R1 reset set_pend", 32'(set_pend), 0);
      check("R1 reset clr/reeval/elig", {clr_pend, reeval, elig}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {set_pend, clr_pend, reeval, elig}, 0);

      // Admission table: R3 R4 R5 R6 R11 R7
      for (int v = 0; v < NV; v++) begin
         logic exp;
         logic [4:0] id;
         {exp, id} = VEC[v][13:8];
         cfg_grp = '0;
         nsac = '0;
         cfg_grp[id*2 +: 2] = VEC[v][5:4];
         nsac[id*2 +: 2] = VEC[v][1:0];
         req_grp = VEC[v][7:6];
         req_ns = VEC[v][3];
         sec_dis = VEC[v][2];
         req_id = id;
         req_valid = 1'b1;
         @(negedge clk);
         check($sformatf("R7 admission vector %0d set_pend/reeval", v),
               {set_pend, reeval}, exp ? {16'(1) << id, 1'b1} : 32'h0);
      end
      req_valid = 1'b0;
      sec_dis = 1'b0;
      req_ns = 1'b0;
      cfg_grp = '0;
      nsac = '0;
      @(negedge clk);
      // R7 strobe lasts a single cycle
      check("R7 strobe drops", {set_pend, reeval}, 0);

      // R2 out-of-range IDs; all interrupts group 0, request group 0
      req_grp = 2'd0;
      req_id = 5'd16;
      req_valid = 1'b1;
      @(negedge clk);
      check("R2 id 16 ignored", {set_pend, reeval}, 0);
      req_id = 5'd31;
      @(negedge clk);
      check("R2 id 31 ignored", {set_pend, reeval}, 0);

      // R8 clear passthrough
      req_valid = 1'b0;
      clr_mask = 16'h00F0;
      @(negedge clk);
      check("R8 clear passthrough", 32'(clr_pend), 32'h00F0);

      // R8 collision: set wins on id 5, id 4 still cleared
      req_id = 5'd5;
      req_valid = 1'b1;
      clr_mask = 16'h0030;
      @(negedge clk);
      check("R8 collision set_pend", 32'(set_pend), 32'h0020);
      check("R8 collision clr_pend", 32'(clr_pend), 32'h0010);
      req_valid = 1'b0;
      clr_mask = '0;

      // R9 / R10 eligibility
      grp_en = 3'b111;
      @(negedge clk);
      check("R9 all eligible", 32'(elig), 32'h7);
      low_power = 1'b1;
      @(negedge clk);
      check("R9 low power", 32'(elig), 0);
      low_power = 1'b0;
      grp_en = 3'b101;
      @(negedge clk);
      check("R9 group disabled", 32'(elig), 32'h5);
      grp_en = 3'b111;
      block = 3'b001;
      @(negedge clk);
      check("R10 block g0", 32'(elig), 32'h6);
      block = 3'b010;
      @(negedge clk);
      check("R10 block g1s", 32'(elig), 32'h5);
      block = 3'b100;
      @(negedge clk);
      check("R10 block g1ns", 32'(elig), 32'h3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule